// File: doc/BRIEF.md
# Supply-controller I2C control/status register slave

This block is the two-wire serial port of a supply controller. It owns a single 8-bit register: six control bits that software writes, and two diagnostic flags that hardware drives. A bus master addresses the block with a 7-bit address whose five upper bits are fixed and whose two lower bits come from a board-level strap. After a write address, every data byte the master sends updates the control bits. After a read address, the block returns the whole register and sends it again after each byte the master acknowledges.

SCL and SDA are sampled into the system clock. Bus events (start, stop, clock edges) are found on the synchronized copies. The block pulls SDA low only through an open-drain enable. A synchronous power-good input gates the port. While power is not good, the block acknowledges nothing, drops any transfer in progress and holds the control bits at zero.

Top module: `i2c_ctrl_reg_slave`

## Requirements
- R1: The block acknowledges, by driving SDA low during the ninth clock, an address byte whose bits 7..3 are 00010, whose bits 2..1 equal `addr_strap_i` and whose bit 0 is the direction (0 write, 1 read).
- R2: After an address byte that does not match, the block never pulls SDA low and the register keeps its value until the next START.
- R3: After a matching write address, each data byte is acknowledged and its bits 7..2 are loaded into `ctrl_o[5:0]`, with data bit 7 going to `ctrl_o[5]`.
- R4: Bits 1..0 of a written data byte have no effect: the read-only positions always reflect the flag inputs.
- R5: A read returns, MSB first, `{ctrl_o[5:0], flag_ot_i, flag_ol_i}`: the over-temperature flag at bit 1 and the overload flag at bit 0, sampled live when each byte starts.
- R6: In read mode, a master acknowledge (SDA low on the ninth clock) makes the block send a further byte. A not-acknowledge ends the read, and SDA is released.
- R7: After reset, `ctrl_o` is zero and SDA is not pulled.
- R8: While `pwr_good_i` is low, `ctrl_o` is zero, SDA is not pulled, and writes have no effect, including after power returns.
- R9: A STOP ends any transfer and releases SDA. A START received in the middle of a transfer restarts address reception without writing the partial byte.
- R10: The SDA pull-down changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_strap_i | input | 2 | Low two bits of the device address |
| pwr_good_i | input | 1 | Supply above lockout threshold (synchronous) |
| flag_ot_i | input | 1 | Over-temperature diagnostic flag |
| flag_ol_i | input | 1 | Overload diagnostic flag |
| sda_pd_o | output | 1 | Open-drain pull-down enable for SDA |
| ctrl_o | output | 6 | Control bits, MSB first as written |

## Verification
The assertions check four rules on every clock: the pull-down changes only during SCL low, the control bits move only on a write strobe or a power loss, nothing is driven or held while power is not good, and a STOP releases SDA. Address decoding over the strap values, which bits of a byte are taken and which are ignored, the order of bits in a read, the live flags in repeated reads, the effect of a repeated START and the behaviour after power returns can only be seen in the bench's transactions. The bench sweeps every strap against 32 addresses and every value of the six control bits.

// File: rtl/i2c_creg_pkg.sv
package i2c_creg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CTRL_W = 6;
  localparam int unsigned FLAG_W = BYTE_W - CTRL_W;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_WR,
    PH_WR_ACK,
    PH_RD,
    PH_RD_ACK
  } phase_e;
endpackage

// File: rtl/i2c_creg_line_sync.sv
module i2c_creg_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s_o    = scl_ff[STAGES-1];
  assign sda_s_o    = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  // SDA edges while SCL held high
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/i2c_creg_fsm.sv
module i2c_creg_fsm
  import i2c_creg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned STRAP_W = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] DEV_BASE = 5'b00010
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               sda_s_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_word_i,
  output logic               sda_pd_o,
  output logic               wr_stb_o,
  output logic [BYTE_W-1:0]  wr_data_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  phase_e            phase_q;
  logic [BYTE_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rd_dir_q;
  logic              more_q;
  logic              wr_stb_q;
  logic              addr_hit;

  assign addr_hit = (shift_q[BYTE_W-1:1] == {DEV_BASE, strap_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      shift_q  <= '0;
      cnt_q    <= '0;
      rd_dir_q <= 1'b0;
      more_q   <= 1'b0;
      wr_stb_q <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      if (!enable_i || stop_i) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
      end else if (start_i) begin
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_ADDR: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              shift_q <= {shift_q[BYTE_W-2:0], sda_s_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              rd_dir_q <= shift_q[0];
              phase_q  <= addr_hit ? PH_ADDR_ACK : PH_IDLE;
            end
          end
          PH_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rd_dir_q) begin
                phase_q <= PH_RD;
                shift_q <= rd_word_i;
              end else begin
                phase_q <= PH_WR;
              end
            end
          end
          PH_WR: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              shift_q <= {shift_q[BYTE_W-2:0], sda_s_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              phase_q  <= PH_WR_ACK;
              wr_stb_q <= 1'b1;
            end
          end
          PH_WR_ACK: begin
            if (scl_fall_i) begin
              phase_q <= PH_WR;
              cnt_q   <= '0;
            end
          end
          PH_RD: begin
            if (scl_fall_i) begin
              if (cnt_q == CNT_LAST) begin
                phase_q <= PH_RD_ACK;
              end else begin
                shift_q <= {shift_q[BYTE_W-2:0], 1'b1};
                cnt_q   <= cnt_q + 1'b1;
              end
            end
          end
          PH_RD_ACK: begin
            if (scl_rise_i) begin
              more_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              cnt_q <= '0;
              if (more_q) begin
                phase_q <= PH_RD;
                shift_q <= rd_word_i;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pd_o  = (phase_q == PH_ADDR_ACK) || (phase_q == PH_WR_ACK) ||
                     (phase_q == PH_RD && !shift_q[BYTE_W-1]);
  assign wr_stb_o  = wr_stb_q;
  assign wr_data_o = shift_q;
endmodule

// File: rtl/i2c_creg_reg.sv
module i2c_creg_reg
  import i2c_creg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              wr_stb_i,
  input  logic [CTRL_W-1:0] wr_ctrl_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] rd_word_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (!enable_i) ctrl_q <= '0;
    else if (wr_stb_i)  ctrl_q <= wr_ctrl_i;
  end

  assign ctrl_o    = ctrl_q;
  assign rd_word_o = {ctrl_q, flags_i};
endmodule

// File: rtl/i2c_ctrl_reg_slave.sv
module i2c_ctrl_reg_slave
  import i2c_creg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_strap_i,
  input  logic              pwr_good_i,
  input  logic              flag_ot_i,
  input  logic              flag_ol_i,
  output logic              sda_pd_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb;
  logic [BYTE_W-1:0] wr_data, rd_word;

  i2c_creg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_sync),
    .sda_s_o    (sda_sync),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_creg_fsm #(.ADDR_W(7), .STRAP_W(2), .DEV_BASE(5'b00010)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (pwr_good_i),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_s_i    (sda_sync),
    .strap_i    (addr_strap_i),
    .rd_word_i  (rd_word),
    .sda_pd_o   (sda_pd_o),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data)
  );

  i2c_creg_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (pwr_good_i),
    .wr_stb_i  (wr_stb),
    .wr_ctrl_i (wr_data[BYTE_W-1:FLAG_W]),
    .flags_i   ({flag_ot_i, flag_ol_i}),
    .ctrl_o    (ctrl_o),
    .rd_word_o (rd_word)
  );
endmodule

// File: rtl/i2c_ctrl_reg_slave_chk.sv
module i2c_ctrl_reg_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_good_i,
  input logic       sda_pd_o,
  input logic [5:0] ctrl_o,
  input logic       scl_sync,
  input logic       wr_stb,
  input logic       stop_det
);
  AST_NO_DRIVE_UNPOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !sda_pd_o); // R8
  AST_CTRL_ZERO_UNPOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (ctrl_o == '0)); // R8
  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(wr_stb || !pwr_good_i)); // R3
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && pwr_good_i) |=> !sda_pd_o); // R9
  AST_PD_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && $past(pwr_good_i) && !$stable(sda_pd_o)) |-> !$past(scl_sync)); // R10
endmodule

bind i2c_ctrl_reg_slave i2c_ctrl_reg_slave_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_good_i (pwr_good_i),
  .sda_pd_o   (sda_pd_o),
  .ctrl_o     (ctrl_o),
  .scl_sync   (scl_sync),
  .wr_stb     (wr_stb),
  .stop_det   (stop_det)
);

// File: tb/i2c_ctrl_reg_slave_tb_top.sv
module i2c_ctrl_reg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic       pwr_good = 1'b1;
  logic       f_ot = 1'b0;
  logic       f_ol = 1'b0;
  logic       sda_pd;
  logic [5:0] ctrl;
  wire        sda_bus = sda_m & ~sda_pd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ctrl_reg_slave dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .addr_strap_i (strap),
    .pwr_good_i   (pwr_good),
    .flag_ot_i    (f_ot),
    .flag_ol_i    (f_ol),
    .sda_pd_o     (sda_pd),
    .ctrl_o       (ctrl)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; w(Q);
    scl_m = 1'b1; w(2*Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    b = sda_bus; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    begin logic b; recv_bit(b); ack = ~b; end
  endtask

  task automatic recv_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin logic b; recv_bit(b); d[i] = b; end
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] d,
                           output logic ack_a, output logic ack_d);
    i2c_start();
    send_byte({a, 1'b0}, ack_a);
    send_byte(d, ack_d);
    i2c_stop();
  endtask

  initial begin
    logic ack_a, ack_d;
    logic [7:0] rd;
    logic [5:0] cur;
    w(5); rst_n = 1'b1; w(5);
    chk("R7 ctrl after reset", ctrl, 0);
    chk("R7 sda after reset", sda_pd, 0);

    // address sweep over all straps
    cur = 6'h2A;
    write_reg(7'h08, {cur, 2'b00}, ack_a, ack_d);
    chk("R3 preload", ctrl, cur);
    for (int s = 0; s < 4; s++) begin
      strap = s[1:0];
      write_reg(7'(8 + s), {cur, 2'b00}, ack_a, ack_d);
      for (int a = 0; a < 32; a++) begin
        logic hit;
        hit = (a[6:2] == 5'b00010) && (a[1:0] == s[1:0]);
        write_reg(a[6:0], hit ? {cur, 2'b11} : {~cur, 2'b00}, ack_a, ack_d);
        if (hit) begin
          chk("R1 address ack", ack_a, 1);
          chk("R3 data ack", ack_d, 1);
        end else begin
          chk("R2 no address ack", ack_a, 0);
          chk("R2 no data ack", ack_d, 0);
        end
        chk("R2 register kept", ctrl, cur);
      end
    end

    // full sweep of control values with read back
    strap = 2'd2;
    for (int v = 0; v < 64; v++) begin
      logic [1:0] fl;
      fl = v[1:0] ^ v[5:4];
      write_reg(7'h0A, {v[5:0], ~fl}, ack_a, ack_d);
      chk("R3 ctrl load", ctrl, v);
      f_ot = fl[1]; f_ol = fl[0];
      i2c_start();
      send_byte(8'h15, ack_a);
      chk("R1 read address ack", ack_a, 1);
      recv_byte(rd);
      send_bit(1'b1);
      i2c_stop();
      chk("R5 read word", rd, {v[5:0], fl});
      chk("R4 flags ignore written lsbs", rd[1:0], fl);
    end

    // multi-byte read with live flags
    f_ot = 1'b0; f_ol = 1'b0;
    write_reg(7'h0A, 8'hB4, ack_a, ack_d);
    i2c_start();
    send_byte(8'h15, ack_a);
    recv_byte(rd);
    chk("R5 first byte", rd, 8'hB4);
    f_ot = 1'b1; f_ol = 1'b1;
    send_bit(1'b0);
    recv_byte(rd);
    chk("R6 second byte after ack", rd, 8'hB7);
    send_bit(1'b1);
    w(2);
    chk("R6 released after nack", sda_pd, 0);
    i2c_stop();
    chk("R9 released after stop", sda_pd, 0);

    // repeated start mid write byte
    write_reg(7'h0A, 8'h54, ack_a, ack_d);
    i2c_start();
    send_byte(8'h14, ack_a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_start();
    send_byte(8'h15, ack_a);
    chk("R9 ack after restart", ack_a, 1);
    recv_byte(rd);
    send_bit(1'b1);
    i2c_stop();
    chk("R9 partial byte discarded", rd, 8'h57);
    chk("R9 ctrl unchanged", ctrl, 6'h15);

    // power-good gating
    pwr_good = 1'b0; w(3);
    chk("R8 ctrl cleared", ctrl, 0);
    write_reg(7'h0A, 8'hFC, ack_a, ack_d);
    chk("R8 no ack unpowered", ack_a, 0);
    chk("R8 write ignored", ctrl, 0);
    pwr_good = 1'b1; w(3);
    f_ot = 1'b1; f_ol = 1'b0;
    i2c_start();
    send_byte(8'h15, ack_a);
    recv_byte(rd);
    send_bit(1'b1);
    i2c_stop();
    chk("R8 read after power return", rd, 8'h02);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule